// File: doc/BRIEF.md
# Multi-Channel Pulse Width Modulator with Buffered Duty Updates

This block drives a bank of pulse outputs from one shared time base. A prescaler divides the clock into ticks. A period counter advances once per tick, runs from zero up to a programmable limit and then wraps. Each channel holds two edge values. In pulse-width mode the output sets when the counter reaches the set-edge value and clears when it reaches the clear-edge value. A channel built as a converter ignores the time base. It runs a first-order accumulator that emits one-clock pulses whose density equals the set-edge value divided by 2^CNT_W.

Two build-time masks decide each channel's structure. One mask picks the channels that get a buffered copy of both edge registers. The other mask picks the channels that run as a pulse-density converter. When the runtime sync bit is set, writes to a buffered channel land only in its buffer. Every buffered channel then copies its buffer into its live registers on the same wrap of the period counter. Channels without a buffer, or any channel while the sync bit is clear, update their live registers on the write itself. A runtime mask inverts any output. Software reaches the block through a simple select/write/address/data port, and reads return data in the same cycle.

Top module: `pwm_shadow_top`

## Requirements
- R1: While reset is held and in the first cycle after it, every output is low. Every readable register then returns 0.
- R2: The prescaler produces one tick every PRESCALE+1 clocks. The period counter advances by one per tick and returns to 0 on the tick where it is at or above PERIOD, so one period lasts (PERIOD+1)*(PRESCALE+1) clocks. Register addresses: 0x00 is PRESCALE, 0x01 is PERIOD.
- R3: In pulse-width mode with set-edge S below clear-edge C (both at most PERIOD), the output is high for C-S counter values per period. The output changes only after a tick or a bus write.
- R4: In pulse-width mode with S above C, the high phase wraps through zero and lasts (PERIOD+1)-(S-C) counter values per period.
- R5: In pulse-width mode with S equal to C, the output stays low.
- R6: Bit c of the invert register (address 0x03) inverts output c.
- R7: A channel without a buffer, or any channel while the sync bit is clear, applies an edge write to its live register on the clock edge of the write. The edge registers sit at address 0x40+2c (set-edge) and 0x41+2c (clear-edge).
- R8: With the sync bit set (address 0x02, bit 0), the live edges of a buffered channel stay fixed until the next counter wrap. At that wrap, all buffered channels load their buffers together.
- R9: A read of an edge register returns the value last written to it, including a value still pending in a buffer. Reads of PRESCALE, PERIOD, the control register and the invert register return their stored values.
- R10: A converter channel emits exactly S ones in any 2^CNT_W consecutive clocks when the prescaler is 0. With S equal to 0 it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle |
| pwm_o | output | NUM_CH | Channel outputs after inversion |

## Verification
On every cycle the assertions check the following:
- the counter holds between ticks and returns to zero after a wrap
- pulse-width outputs change only after a tick or a write
- equal edges drive the output low
- buffered live edges stay fixed in sync mode except at a wrap
- unbuffered writes reach the live registers one edge later
- outputs are low after reset and a zero-density converter is silent.

The bench scenarios show what needs a whole period: the high-time counts for ordinary and wrapping edge pairs, the scaling by the prescaler, the effect of inversion, and the exact pulse density of the converter. They also show the phase-dependent contrast: a buffered write has no effect in its own period and appears in the next, while an unbuffered or async write acts within the current period.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 16;
    localparam int CHF_W  = ADDR_W - 2;

    localparam logic [ADDR_W-1:0] A_PRESCALE  = 7'h00;
    localparam logic [ADDR_W-1:0] A_PERIOD    = 7'h01;
    localparam logic [ADDR_W-1:0] A_CTRL      = 7'h02;
    localparam logic [ADDR_W-1:0] A_INVERT    = 7'h03;
    localparam logic [ADDR_W-1:0] A_EDGE_BASE = 7'h40;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CFG,
        ACC_EDGE
    } acc_kind_e;

    typedef struct packed {
        logic             hit;
        logic             is_fall;
        logic [CHF_W-1:0] ch;
    } edge_dec_t;

    typedef struct packed {
        acc_kind_e         kind;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic edge_dec_t decode_edge(input logic [ADDR_W-1:0] a);
        edge_dec_t d;
        d.hit     = a[ADDR_W-1];
        d.is_fall = a[0];
        d.ch      = a[ADDR_W-2:1];
        return d;
    endfunction

    function automatic logic [ADDR_W-1:0] edge_addr(input int ch, input logic fall);
        return A_EDGE_BASE + ADDR_W'(2 * ch) + ADDR_W'(fall);
    endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] prescale,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             tick,
    output logic             period_start
);
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    assign tick         = (pre_q >= prescale);
    assign period_start = tick && (cnt_q >= period);
    assign cnt          = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (period_start) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CNT_W      = 8,
    parameter bit HAS_SHADOW = 1'b0,
    parameter bit DAC_MODE   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_rise,
    input  logic             wr_fall,
    input  logic [CNT_W-1:0] wdata,
    input  logic             sync_en,
    input  logic             period_start,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             invert,
    output logic [CNT_W-1:0] rd_rise,
    output logic [CNT_W-1:0] rd_fall,
    output logic [CNT_W-1:0] act_rise,
    output logic [CNT_W-1:0] act_fall,
    output logic             pwm_raw,
    output logic             pwm_out
);
    logic [CNT_W-1:0] rise_q, fall_q;
    logic             out_q;

    generate
        if (HAS_SHADOW) begin : g_buf
            logic [CNT_W-1:0] rise_sh, fall_sh;

            always_ff @(posedge clk) begin
                if (rst) begin
                    rise_sh <= '0;
                    fall_sh <= '0;
                end else begin
                    if (wr_rise) rise_sh <= wdata;
                    if (wr_fall) fall_sh <= wdata;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    rise_q <= '0;
                    fall_q <= '0;
                end else if (sync_en) begin
                    if (period_start) begin
                        rise_q <= rise_sh;
                        fall_q <= fall_sh;
                    end
                end else begin
                    if (wr_rise) rise_q <= wdata;
                    if (wr_fall) fall_q <= wdata;
                end
            end

            assign rd_rise = rise_sh;
            assign rd_fall = fall_sh;
        end else begin : g_direct
            always_ff @(posedge clk) begin
                if (rst) begin
                    rise_q <= '0;
                    fall_q <= '0;
                end else begin
                    if (wr_rise) rise_q <= wdata;
                    if (wr_fall) fall_q <= wdata;
                end
            end

            assign rd_rise = rise_q;
            assign rd_fall = fall_q;
        end
    endgenerate

    generate
        if (DAC_MODE) begin : g_dac
            logic [CNT_W-1:0] acc_q;
            logic [CNT_W:0]   sum;

            assign sum = {1'b0, acc_q} + {1'b0, rise_q};

            always_ff @(posedge clk) begin
                if (rst) begin
                    acc_q <= '0;
                    out_q <= 1'b0;
                end else if (tick) begin
                    acc_q <= sum[CNT_W-1:0];
                    out_q <= sum[CNT_W];
                end
            end
        end else begin : g_pwm
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_q <= 1'b0;
                end else if (rise_q == fall_q) begin
                    out_q <= 1'b0;
                end else if (cnt == rise_q) begin
                    out_q <= 1'b1;
                end else if (cnt == fall_q) begin
                    out_q <= 1'b0;
                end
            end
        end
    endgenerate

    assign act_rise = rise_q;
    assign act_fall = fall_q;
    assign pwm_raw  = out_q;
    assign pwm_out  = out_q ^ invert;
endmodule

// File: rtl/pwm_shadow_top.sv
module pwm_shadow_top
    import pwm_shadow_pkg::*;
#(
    parameter int              NUM_CH      = 16,
    parameter int              CNT_W       = 8,
    parameter int              PRE_W       = 8,
    parameter logic [NUM_CH-1:0] SHADOW_MASK = 16'h00F1,
    parameter logic [NUM_CH-1:0] DAC_MASK    = 16'h0008
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_o
);
    logic [PRE_W-1:0]  prescale_q;
    logic [CNT_W-1:0]  period_q;
    logic              sync_q;
    logic [NUM_CH-1:0] invert_q;

    logic [CNT_W-1:0]  cnt;
    logic              tick, period_start;

    bus_req_t  req;
    edge_dec_t dec;
    logic      wr_en;

    logic [NUM_CH-1:0]            wr_rise, wr_fall;
    logic [NUM_CH-1:0][CNT_W-1:0] rd_rise, rd_fall;
    logic [NUM_CH-1:0][CNT_W-1:0] act_rise, act_fall;
    logic [NUM_CH-1:0]            pwm_raw;

    always_comb begin
        dec      = decode_edge(bus_addr);
        req.we   = bus_sel && bus_write;
        req.addr = bus_addr;
        req.data = bus_wdata;
        if (!bus_sel)     req.kind = ACC_NONE;
        else if (dec.hit) req.kind = ACC_EDGE;
        else              req.kind = ACC_CFG;
    end

    assign wr_en = req.we;

    always_ff @(posedge clk) begin
        if (rst) begin
            prescale_q <= '0;
            period_q   <= '0;
            sync_q     <= 1'b0;
            invert_q   <= '0;
        end else if (req.we && req.kind == ACC_CFG) begin
            case (req.addr)
                A_PRESCALE: prescale_q <= req.data[PRE_W-1:0];
                A_PERIOD:   period_q   <= req.data[CNT_W-1:0];
                A_CTRL:     sync_q     <= req.data[0];
                A_INVERT:   invert_q   <= req.data[NUM_CH-1:0];
                default:    ;
            endcase
        end
    end

    pwm_timebase #(
        .CNT_W(CNT_W),
        .PRE_W(PRE_W)
    ) u_timebase (
        .clk         (clk),
        .rst         (rst),
        .prescale    (prescale_q),
        .period      (period_q),
        .cnt         (cnt),
        .tick        (tick),
        .period_start(period_start)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign wr_rise[c] = req.we && req.kind == ACC_EDGE &&
                                dec.ch == CHF_W'(c) && !dec.is_fall;
            assign wr_fall[c] = req.we && req.kind == ACC_EDGE &&
                                dec.ch == CHF_W'(c) && dec.is_fall;

            pwm_channel #(
                .CNT_W     (CNT_W),
                .HAS_SHADOW(SHADOW_MASK[c]),
                .DAC_MODE  (DAC_MASK[c])
            ) u_ch (
                .clk         (clk),
                .rst         (rst),
                .wr_rise     (wr_rise[c]),
                .wr_fall     (wr_fall[c]),
                .wdata       (req.data[CNT_W-1:0]),
                .sync_en     (sync_q),
                .period_start(period_start),
                .tick        (tick),
                .cnt         (cnt),
                .invert      (invert_q[c]),
                .rd_rise     (rd_rise[c]),
                .rd_fall     (rd_fall[c]),
                .act_rise    (act_rise[c]),
                .act_fall    (act_fall[c]),
                .pwm_raw     (pwm_raw[c]),
                .pwm_out     (pwm_o[c])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (dec.hit) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (dec.ch == CHF_W'(c)) begin
                    bus_rdata = dec.is_fall ? DATA_W'(rd_fall[c]) : DATA_W'(rd_rise[c]);
                end
            end
        end else begin
            case (bus_addr)
                A_PRESCALE: bus_rdata = DATA_W'(prescale_q);
                A_PERIOD:   bus_rdata = DATA_W'(period_q);
                A_CTRL:     bus_rdata = DATA_W'(sync_q);
                A_INVERT:   bus_rdata = DATA_W'(invert_q);
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk
    import pwm_shadow_pkg::*;
#(
    parameter int                NUM_CH      = 16,
    parameter int                CNT_W       = 8,
    parameter logic [NUM_CH-1:0] SHADOW_MASK = 16'h00F1,
    parameter logic [NUM_CH-1:0] DAC_MASK    = 16'h0008
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          tick,
    input logic                          period_start,
    input logic [CNT_W-1:0]              cnt,
    input logic                          sync_en,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [NUM_CH-1:0][CNT_W-1:0]  act_rise,
    input logic [NUM_CH-1:0][CNT_W-1:0]  act_fall,
    input logic [NUM_CH-1:0]             pwm_raw,
    input logic [NUM_CH-1:0]             pwm_o
);
    assert_reset_low_R1: assert property (@(posedge clk)
        $past(rst) |-> pwm_o == '0);

    assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (rst)
        period_start |=> cnt == '0);

    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            if (!DAC_MASK[c]) begin : g_pwm
                assert_equal_edges_low_R5: assert property (@(posedge clk) disable iff (rst)
                    act_rise[c] == act_fall[c] |=> !pwm_raw[c]);

                assert_change_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
                    (!$past(tick, 2) && !$past(wr_en, 2)) |-> $stable(pwm_raw[c]));
            end else begin : g_dac
                assert_zero_density_R10: assert property (@(posedge clk) disable iff (rst)
                    act_rise[c] == '0 |=> !pwm_raw[c]);
            end

            if (SHADOW_MASK[c]) begin : g_buf
                assert_hold_until_wrap_R8: assert property (@(posedge clk) disable iff (rst)
                    (sync_en && !period_start) |=> ($stable(act_rise[c]) && $stable(act_fall[c])));
            end else begin : g_direct
                assert_direct_write_R7: assert property (@(posedge clk) disable iff (rst)
                    (wr_en && bus_addr == edge_addr(c, 1'b0))
                    |=> act_rise[c] == $past(bus_wdata[CNT_W-1:0]));
            end
        end
    endgenerate
endmodule

bind pwm_shadow_top pwm_shadow_chk #(
    .NUM_CH     (NUM_CH),
    .CNT_W      (CNT_W),
    .SHADOW_MASK(SHADOW_MASK),
    .DAC_MASK   (DAC_MASK)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .period_start(period_start),
    .cnt         (cnt),
    .sync_en     (sync_q),
    .wr_en       (wr_en),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .act_rise    (act_rise),
    .act_fall    (act_fall),
    .pwm_raw     (pwm_raw),
    .pwm_o       (pwm_o)
);

// File: tb/pwm_shadow_top_tb_top.sv
module pwm_shadow_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_write = 1'b0;
    logic [6:0]        bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic [NUM_CH-1:0] pwm_o;

    int checks = 0;
    int failures = 0;
    int pend = 0;
    int done = 0;
    bit finished = 0;

    typedef struct {
        string req;
        int    ch;
        int    win;
        int    exp;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_shadow_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pwm_o    (pwm_o)
    );

    function automatic logic [6:0] ea(input int ch, input int fall);
        return 7'(7'h40 + 2 * ch + fall);
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [6:0] a, input int d);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = 16'(d);
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_write = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_rd(input string req, input logic [6:0] a, input int exp);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata == 16'(exp), int'(bus_rdata), exp);
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    // driver side of the scoreboard: queue an expected high count and wait for the monitor
    task automatic expect_ones(input string req, input int ch, input int win, input int exp);
        item_t it;
        it.req = req; it.ch = ch; it.win = win; it.exp = exp;
        sb_q.push_back(it);
        pend++;
        wait (done == pend);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic align_ref();
        @(posedge pwm_o[1]);
        @(negedge clk);
    endtask

    // monitor: pops expected items and counts output highs away from the clock edge
    initial begin
        forever begin
            item_t it;
            int ones;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            ones = 0;
            repeat (it.win) begin
                @(negedge clk);
                if (pwm_o[it.ch]) ones++;
            end
            check(it.req, ones == it.exp, ones, it.exp);
            done++;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: outputs low during reset
        check("R1 outputs in reset", pwm_o == '0, int'(pwm_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs after reset", pwm_o == '0, int'(pwm_o), 0);
        bus_rd("R1 prescale reset", 7'h00, 0);
        bus_rd("R1 period reset", 7'h01, 0);
        bus_rd("R1 edge reset", ea(0, 0), 0);

        // R3: ordinary edge pair, period 10 counts
        bus_wr(7'h01, 9);
        bus_wr(ea(1, 0), 2);
        bus_wr(ea(1, 1), 7);
        // R4: wrapping edge pair
        bus_wr(ea(2, 0), 8);
        bus_wr(ea(2, 1), 1);
        // R5: equal edges on a buffered channel with sync clear
        bus_wr(ea(4, 0), 4);
        bus_wr(ea(4, 1), 4);
        idle(20);
        expect_ones("R3 set<clear high time", 1, 100, 50);
        expect_ones("R4 wrapped high time", 2, 100, 30);
        expect_ones("R5 equal edges low", 4, 100, 0);

        // R6: invert channel 4 only
        bus_wr(7'h03, 16'h0010);
        idle(3);
        expect_ones("R6 inverted output", 4, 100, 100);
        expect_ones("R6 other channel unaffected", 1, 100, 50);
        bus_wr(7'h03, 0);

        // R2: prescaler 3 stretches each count to 4 clocks
        bus_wr(7'h00, 3);
        idle(60);
        expect_ones("R2 prescaled high time", 1, 200, 100);

        // R9: readback of config and edge registers
        bus_rd("R9 prescale readback", 7'h00, 3);
        bus_rd("R9 period readback", 7'h01, 9);
        bus_rd("R9 edge readback", ea(2, 0), 8);
        bus_wr(7'h03, 16'h00A5);
        bus_rd("R9 invert readback", 7'h03, 16'h00A5);
        bus_wr(7'h03, 0);

        // reference pulse on channel 1 at counter 0, 256-count period
        bus_wr(7'h00, 0);
        bus_wr(7'h01, 255);
        bus_wr(ea(1, 0), 0);
        bus_wr(ea(1, 1), 1);
        bus_wr(ea(2, 0), 0);
        bus_wr(ea(2, 1), 0);
        bus_wr(7'h02, 1);
        bus_rd("R9 control readback", 7'h02, 1);
        idle(300);

        // R8: buffered write has no effect in its own period
        align_ref();
        bus_wr(ea(0, 0), 50);
        bus_wr(ea(0, 1), 100);
        bus_rd("R9 pending buffer readback", ea(0, 0), 50);
        expect_ones("R8 buffered write held", 0, 150, 0);
        align_ref();
        expect_ones("R8 loaded at wrap", 0, 256, 50);

        // R7: unbuffered channel ignores sync bit
        align_ref();
        bus_wr(ea(2, 0), 50);
        bus_wr(ea(2, 1), 120);
        expect_ones("R7 unbuffered immediate", 2, 150, 70);

        // R7: buffered channel with sync clear applies at once
        bus_wr(7'h02, 0);
        align_ref();
        bus_wr(ea(0, 1), 150);
        expect_ones("R7 async buffered immediate", 0, 150, 100);

        // R10: converter density over 256 clocks
        bus_wr(ea(3, 0), 77);
        idle(5);
        expect_ones("R10 density 77", 3, 256, 77);
        bus_wr(ea(3, 0), 255);
        idle(5);
        expect_ones("R10 density 255", 3, 256, 255);
        bus_wr(ea(3, 0), 0);
        idle(5);
        expect_ones("R10 density 0", 3, 256, 0);

        idle(5);
        finish_run();
    end
endmodule